// File: doc/BRIEF.md
# Extended peripheral select decoder

This block connects the I/O bus of a small processor to a user logic fabric. Four adjacent I/O addresses act as base ports. A 2-bit extension value, held in a local control register, picks one of four lines behind each base port. Together they give sixteen one-hot select lines. Each select line addresses one register in the fabric.

The processor's read and write enables pass to the fabric only when the access hits one of the four base ports. The write data goes to the fabric unchanged, and fabric read data returns on the processor read bus. While reset is held, the block raises every select line and the fabric write strobe, and it forces the data to zero. Every fabric register tied to a select line therefore clears during reset, with no software action.

The extension register sits at its own I/O address. Software writes it first and then accesses a base port.

Top module: `xsel_decoder`

## Requirements
- R1: Only the I/O addresses 0x14, 0x15, 0x16 and 0x17 are base ports. A read or write at any other address leaves all 16 select lines low and both fabric strobes low.
- R2: During a base-port access exactly one select line is high. Its index is 4 × (address − 0x14) + extension value, so address 0x14 maps to lines 0–3 and address 0x17 maps to lines 12–15.
- R3: The fabric read strobe equals the processor read enable qualified by a base-port hit. The fabric write strobe equals the processor write enable qualified the same way.
- R4: Outside reset, with neither enable high, all select lines are low.
- R5: While reset (rst_n low) is held, all 16 select lines are high, the fabric write strobe is high, the fabric read strobe is low and the fabric write data is 8'h00, whatever the bus inputs are.
- R6: The extension register is at I/O address 0x1D and holds bits [1:0] of the written byte. It resets to 0. A read of 0x1D returns the value in bits [1:0], with bits [7:2] reading as zero. Writing ones to bits [7:2] has no effect.
- R7: A write to 0x1D changes the select mapping from the next clock cycle onward. The access that writes the register drives no select line.
- R8: Outside reset, the fabric write data equals the processor write data. A read of a base port returns the fabric read data on io_rdata. Any other read, apart from address 0x1D, returns 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 6 | Processor I/O address |
| io_wdata | input | 8 | Processor write data |
| io_rd | input | 1 | Processor I/O read enable |
| io_wr | input | 1 | Processor I/O write enable |
| io_rdata | output | 8 | Read data back to the processor |
| fab_rdata | input | 8 | Read data from the fabric |
| fab_sel | output | 16 | One-hot fabric register selects |
| fab_rd | output | 1 | Qualified fabric read strobe |
| fab_wr | output | 1 | Qualified fabric write strobe |
| fab_wdata | output | 8 | Write data to the fabric |

## Verification
The extension register is the only state in the block, and every fault in it shows up at the ports. A register that captures the wrong bits or misses a write moves the selected line within its group of four. That error appears on fab_sel in the first base-port access after the write, and on io_rdata in the first read of 0x1D. A register that fails to clear on reset, or updates in the same cycle as the write, shows on the access that follows at once. The bench therefore places back-to-back write-then-access pairs and reset pulses in the middle of the run.

// File: rtl/xsel_decoder.sv
module xsel_decoder #(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 8,
  parameter int EXT_W    = 2,
  parameter int NUM_BASE = 4,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 6'h14,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 6'h1D,
  localparam int GRP   = 1 << EXT_W,
  localparam int SEL_W = NUM_BASE * GRP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [DATA_W-1:0] io_wdata,
  input  logic              io_rd,
  input  logic              io_wr,
  output logic [DATA_W-1:0] io_rdata,
  input  logic [DATA_W-1:0] fab_rdata,
  output logic [SEL_W-1:0]  fab_sel,
  output logic              fab_rd,
  output logic              fab_wr,
  output logic [DATA_W-1:0] fab_wdata
);

  logic [EXT_W-1:0]  ext_q;
  logic [ADDR_W-1:0] offs;
  logic              hit, acc, ctrl_hit;
  logic [SEL_W-1:0]  dec_sel;

  assign offs     = io_addr - BASE_ADDR;
  assign hit      = offs < ADDR_W'(NUM_BASE);
  assign acc      = io_rd | io_wr;
  assign ctrl_hit = io_addr == CTRL_ADDR;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                ext_q <= '0;
    else if (io_wr && ctrl_hit) ext_q <= io_wdata[EXT_W-1:0];

  for (genvar g = 0; g < NUM_BASE; g++) begin : g_base
    logic base_hit;
    assign base_hit = hit && (offs == ADDR_W'(g));
    for (genvar e = 0; e < GRP; e++) begin : g_ext
      assign dec_sel[g*GRP+e] = base_hit && (ext_q == EXT_W'(e));
    end
  end

  assign fab_sel   = !rst_n ? '1 : (acc ? dec_sel : '0);
  assign fab_wr    = !rst_n | (io_wr & hit);
  assign fab_rd    = rst_n & io_rd & hit;
  assign fab_wdata = rst_n ? io_wdata : '0;

  always_comb begin
    io_rdata = '0;
    if (io_rd && ctrl_hit)  io_rdata = {{(DATA_W-EXT_W){1'b0}}, ext_q};
    else if (io_rd && hit)  io_rdata = fab_rdata;
  end

  assert_miss_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (int'(io_addr) < int'(BASE_ADDR) || int'(io_addr) >= int'(BASE_ADDR) + NUM_BASE))
      |-> (fab_sel == '0 && !fab_rd && !fab_wr));

  assert_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fab_rd || fab_wr) |-> ($countones(fab_sel) == 1));

  assert_strobe_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fab_rd |-> io_rd) and (fab_wr |-> io_wr));

  assert_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |-> (fab_sel == '0));

  always @(posedge clk)
    if (!rst_n) assert_reset_clear_R5: assert (fab_sel == '1 && fab_wr && !fab_rd && fab_wdata == '0);

  assert_ext_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && ctrl_hit) |=> (ext_q == $past(io_wdata[EXT_W-1:0])));

endmodule

// File: tb/xsel_decoder_tb.sv
module xsel_decoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] CTRL = 6'h1D;

  logic clk = 0, rst_n = 0;
  logic [5:0] io_addr = 0;
  logic [7:0] io_wdata = 0, fab_rdata = 0;
  logic io_rd = 0, io_wr = 0;
  logic [7:0] io_rdata, fab_wdata;
  logic [15:0] fab_sel;
  logic fab_rd, fab_wr;

  int total = 0, bad = 0;
  logic [1:0] exp_ext = 0;
  logic pend = 0;
  logic [1:0] pend_val = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xsel_decoder dut_i (.clk, .rst_n, .io_addr, .io_wdata, .io_rd, .io_wr, .io_rdata,
                      .fab_rdata, .fab_sel, .fab_rd, .fab_wr, .fab_wdata);

  function automatic logic is_base(logic [5:0] a);
    return a >= 6'h14 && a <= 6'h17;
  endfunction

  function automatic logic [15:0] exp_sel(logic [5:0] a, logic [1:0] x, logic rd, logic wr);
    if (!(rd || wr) || !is_base(a)) return 16'h0;
    return 16'h1 << (4 * (a - 6'h14) + x);
  endfunction

  function automatic logic [7:0] exp_rdata(logic [5:0] a, logic [1:0] x, logic rd, logic [7:0] f);
    if (rd && a == CTRL) return {6'b0, x};
    if (rd && is_base(a)) return f;
    return 8'h00;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(logic [5:0] a, logic [7:0] wd, logic rd, logic wr, string tag);
    @(posedge clk);
    if (pend) begin exp_ext = pend_val; pend = 0; end
    #1;
    io_addr = a; io_wdata = wd; io_rd = rd; io_wr = wr; fab_rdata = 8'($urandom);
    #3;
    chk({tag, " sel"}, 32'(fab_sel), 32'(exp_sel(a, exp_ext, rd, wr)));
    chk({tag, " rd"}, 32'(fab_rd), 32'(rd && is_base(a)));
    chk({tag, " wr"}, 32'(fab_wr), 32'(wr && is_base(a)));
    chk({tag, " wdata"}, 32'(fab_wdata), 32'(wd));
    chk({tag, " rdata"}, 32'(io_rdata), 32'(exp_rdata(a, exp_ext, rd, fab_rdata)));
    if (wr && a == CTRL) begin pend = 1; pend_val = wd[1:0]; end
  endtask

  task automatic reset_check(string tag);
    io_addr = 6'h15; io_wdata = 8'hA5; io_rd = 1; io_wr = 0;
    #2;
    chk({tag, " R5 sel"}, 32'(fab_sel), 32'hFFFF);
    chk({tag, " R5 wr"}, 32'(fab_wr), 1);
    chk({tag, " R5 rd"}, 32'(fab_rd), 0);
    chk({tag, " R5 wdata"}, 32'(fab_wdata), 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    reset_check("por");
    repeat (3) @(posedge clk);
    #1 rst_n = 1; io_rd = 0;
    step(CTRL, 8'h00, 1, 0, "R6 reset value");
    step(6'h14, 8'h11, 0, 0, "R4 idle");
    for (int x = 0; x < 4; x++) begin
      step(CTRL, 8'(x), 0, 1, "R7 write ctrl");
      for (int a = 6'h14; a <= 6'h17; a++) begin
        step(6'(a), 8'h5A, 0, 1, "R2 write base");
        step(6'(a), 8'h00, 1, 0, "R3 read base");
      end
    end
    step(CTRL, 8'hFE, 0, 1, "R6 upper bits");
    step(CTRL, 8'h00, 1, 0, "R6 readback");
    step(6'h17, 8'h3C, 0, 1, "R2 top line");
    step(6'h13, 8'h77, 1, 1, "R1 below range");
    step(6'h18, 8'h77, 1, 1, "R1 above range");
    step(6'h34, 8'h77, 1, 1, "R1 data-space alias");
    step(CTRL, 8'h01, 0, 1, "R7 same-cycle");
    step(6'h16, 8'h42, 0, 1, "R7 next cycle");
    for (int i = 0; i < 400; i++) begin
      logic [5:0] a;
      a = 6'h12 + 6'($urandom_range(0, 12));
      step(a, 8'($urandom), 1'($urandom), 1'($urandom), "R8 random");
    end
    step(CTRL, 8'h02, 0, 1, "R7 before reset");
    @(posedge clk); #1 rst_n = 0; pend = 0; exp_ext = 0;
    reset_check("mid");
    @(posedge clk); #1 rst_n = 1;
    step(CTRL, 8'h00, 1, 0, "R6 cleared by reset");
    step(6'h15, 8'h99, 1, 0, "R2 after reset");
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule